// File: doc/BRIEF.md
# Serial Command Frame Receiver with Chain Pass-Through

This block is the device side of a three-wire serial command link: a clock line, an active-low frame line and a data line. Each command is an 18-bit frame. The block samples all three lines in the system clock domain through synchronizers and finds their edges there. It assembles each frame and hands it to the channel logic as a one-cycle strobe that carries a 2-bit operation code, a 4-bit channel index and a 12-bit value.

A static select input picks the commit rule. In single-device use, the receiver commits as soon as the eighteenth bit arrives and ignores any later bits of the same frame. A frame that closes early is dropped. In chained use, the receiver keeps shifting for as long as the frame is open, and passes the overflow bits on through a serial output to the next device. It then commits the last 18 bits it holds when the frame line rises. Operation code 3 is a no-operation: it travels down the chain but produces no strobe. While the channel logic holds the busy input low, serial clock edges are ignored.

Top module: `serial_frame_rx`

## Requirements
- R1: A frame is sent MSB first. Frame bits 17:16 carry the operation code (cmd_mode), bits 15:12 carry the channel index (cmd_addr) and bits 11:0 carry the value (cmd_data). Each accepted frame raises cmd_valid for exactly one cycle.
- R2: Data bits are taken on falling edges of sclk only while the frame is open (frame_n low). Clock edges that arrive while frame_n is high change neither the held bits nor dout.
- R3: A falling edge of frame_n clears the bit count. A new frame needs frame_n to go high and then low again.
- R4: With chain_en = 0, the frame is committed right after its 18th falling edge, and any further sclk edges in that frame are ignored.
- R5: With chain_en = 0, if frame_n rises before the 18th bit, no strobe is produced.
- R6: With chain_en = 1, dout is updated on each sclk rising edge inside an open frame. It presents the bit shifted in 18 falling edges earlier, so N chained devices need 18N clocks. With chain_en = 0, dout is held at 0.
- R7: With chain_en = 1, the last 18 bits received are committed when frame_n rises.
- R8: With chain_en = 1, if frame_n rises after fewer than 18 bits, no strobe is produced.
- R9: Operation code 2'b11 never produces a strobe, but its bits still pass to dout.
- R10: While busy_n is low, sclk edges are ignored in both modes.
- R11: After reset, cmd_valid and dout are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chain_en | input | 1 | Static select: 1 = chained mode, 0 = single-device mode |
| busy_n | input | 1 | Low while the channel logic cannot accept commands |
| sclk | input | 1 | Serial clock (asynchronous) |
| frame_n | input | 1 | Active-low frame enable (asynchronous) |
| din | input | 1 | Serial data in |
| dout | output | 1 | Serial data out to the next device in a chain |
| cmd_valid | output | 1 | One-cycle strobe for an accepted command |
| cmd_mode | output | 2 | Operation code of the command |
| cmd_addr | output | 4 | Channel index of the command |
| cmd_data | output | 12 | Value of the command |

## Verification
The assertions check the following on every cycle:
- no strobe ever carries the no-operation code;
- the strobe never lasts more than one cycle;
- the bit count never passes 18 and holds while busy_n is low;
- dout moves only after a serial clock rise;
- each strobe follows its mode's trigger (the 18th bit in single-device mode, the frame rise in chained mode).

Only the bench's scenarios can show that the committed fields match the bits sent, including the following cases:
- early aborts;
- ignored surplus bits;
- edges dropped under busy or outside a frame;
- the ripple of a frame through two chained receivers.

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
  parameter int FRAME_BITS  = 18,
  parameter int MODE_W      = 2,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             chain_en,
  input  logic                             busy_n,
  input  logic                             sclk,
  input  logic                             frame_n,
  input  logic                             din,
  output logic                             dout,
  output logic                             cmd_valid,
  output logic [MODE_W-1:0]                cmd_mode,
  output logic [ADDR_W-1:0]                cmd_addr,
  output logic [FRAME_BITS-MODE_W-ADDR_W-1:0] cmd_data
);
  localparam int DATA_W = FRAME_BITS - MODE_W - ADDR_W;
  localparam int CNT_W  = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0]  FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0]  LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [MODE_W-1:0] NOP  = '1;

  logic [SYNC_STAGES:0]   sclk_p, frm_p;
  logic [SYNC_STAGES-1:0] din_p;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_p <= '0;
      frm_p  <= '1;
      din_p  <= '0;
    end else begin
      sclk_p <= {sclk_p[SYNC_STAGES-1:0], sclk};
      frm_p  <= {frm_p[SYNC_STAGES-1:0], frame_n};
      din_p  <= {din_p[SYNC_STAGES-2:0], din};
    end

  wire sclk_fall = sclk_p[SYNC_STAGES] & ~sclk_p[SYNC_STAGES-1];
  wire sclk_rise = ~sclk_p[SYNC_STAGES] & sclk_p[SYNC_STAGES-1];
  wire frm_fall  = frm_p[SYNC_STAGES] & ~frm_p[SYNC_STAGES-1];
  wire frm_rise  = ~frm_p[SYNC_STAGES] & frm_p[SYNC_STAGES-1];
  wire din_s     = din_p[SYNC_STAGES-1];

  logic                  open_q, done_q, dout_q;
  logic [CNT_W-1:0]      bit_cnt;
  logic [FRAME_BITS-1:0] sr;

  wire                  take     = open_q & busy_n & ~done_q & sclk_fall;
  wire [FRAME_BITS-1:0] sr_next  = {sr[FRAME_BITS-2:0], din_s};
  wire                  std_hit  = take & ~chain_en & (bit_cnt == LAST);
  wire                  chn_hit  = frm_rise & open_q & chain_en & (bit_cnt == FULL);
  wire [FRAME_BITS-1:0] word     = std_hit ? sr_next : sr;
  wire                  is_nop   = word[FRAME_BITS-1 -: MODE_W] == NOP;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      open_q  <= 1'b0;
      done_q  <= 1'b0;
      bit_cnt <= '0;
      sr      <= '0;
    end else if (frm_fall) begin
      open_q  <= 1'b1;
      done_q  <= 1'b0;
      bit_cnt <= '0;
    end else if (frm_rise) begin
      open_q  <= 1'b0;
    end else if (take) begin
      sr <= sr_next;
      if (bit_cnt != FULL) bit_cnt <= bit_cnt + 1'b1;
      if (std_hit) done_q <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dout_q <= 1'b0;
    else if (!chain_en) dout_q <= 1'b0;
    else if (open_q && busy_n && sclk_rise) dout_q <= sr[FRAME_BITS-1];

  assign dout = dout_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_mode  <= '0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
    end else begin
      cmd_valid <= (std_hit | chn_hit) & ~is_nop;
      if ((std_hit | chn_hit) && !is_nop) begin
        cmd_mode <= word[FRAME_BITS-1 -: MODE_W];
        cmd_addr <= word[DATA_W +: ADDR_W];
        cmd_data <= word[DATA_W-1:0];
      end
    end
endmodule

module serial_frame_rx_chk #(
  parameter int FRAME_BITS = 18,
  parameter int MODE_W     = 2,
  parameter int CNT_W      = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chain_en,
  input logic              busy_n,
  input logic              cmd_valid,
  input logic [MODE_W-1:0] cmd_mode,
  input logic              dout,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              sclk_rise,
  input logic              frm_rise
);
  // R9
  nop_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_mode != '1);
  // R1
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_BITS));
  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |=> (bit_cnt == '0) || $stable(bit_cnt));
  // R6
  dout_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> $past(sclk_rise) || $past(!chain_en));
  // R7
  chain_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && chain_en && $past(chain_en)) |-> $past(frm_rise));
  // R4
  single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !chain_en && $past(!chain_en)) |->
      ($past(bit_cnt) == CNT_W'(FRAME_BITS - 1)) && (bit_cnt == CNT_W'(FRAME_BITS)));
endmodule

bind serial_frame_rx serial_frame_rx_chk #(
  .FRAME_BITS(FRAME_BITS), .MODE_W(MODE_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .chain_en(chain_en), .busy_n(busy_n),
  .cmd_valid(cmd_valid), .cmd_mode(cmd_mode), .dout(dout),
  .bit_cnt(bit_cnt), .sclk_rise(sclk_rise), .frm_rise(frm_rise)
);

// File: tb/sim_serial_frame_rx.sv
module sim_serial_frame_rx;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0, chain_en = 1'b0, busy_n = 1'b1;
  logic sclk = 1'b0, frame_n = 1'b1, din = 1'b0;
  logic dout0, dout1, v0, v1;
  logic [1:0] m0, m1;
  logic [3:0] a0, a1;
  logic [11:0] d0, d1;

  always #2.5 clk = ~clk;

  serial_frame_rx u0 (.clk(clk), .rst_n(rst_n), .chain_en(chain_en), .busy_n(busy_n),
    .sclk(sclk), .frame_n(frame_n), .din(din), .dout(dout0),
    .cmd_valid(v0), .cmd_mode(m0), .cmd_addr(a0), .cmd_data(d0));
  serial_frame_rx u1 (.clk(clk), .rst_n(rst_n), .chain_en(chain_en), .busy_n(busy_n),
    .sclk(sclk), .frame_n(frame_n), .din(dout0), .dout(dout1),
    .cmd_valid(v1), .cmd_mode(m1), .cmd_addr(a1), .cmd_data(d1));

  int tests = 0, fails = 0, n0 = 0, n1 = 0;
  logic [17:0] got0, got1;
  bit finished = 0;

  always @(negedge clk) begin
    if (v0) begin n0 = n0 + 1; got0 = {m0, a0, d0}; end
    if (v1) begin n1 = n1 + 1; got1 = {m1, a1, d1}; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    din = b; wait_clk(H);
    sclk = 1'b1; wait_clk(H);
    sclk = 1'b0; wait_clk(H);
  endtask

  task automatic open_frame();
    n0 = 0; n1 = 0; frame_n = 1'b0; wait_clk(H);
  endtask

  task automatic close_frame();
    frame_n = 1'b1; wait_clk(4 * H);
  endtask

  task automatic send18(input logic [17:0] w);
    for (int i = 17; i >= 0; i--) pulse(w[i]);
  endtask

  function automatic logic [17:0] mk(input int m, input int a, input int d);
    return {2'(m), 4'(a), 12'(d)};
  endfunction

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    wait_clk(5); rst_n = 1'b1; wait_clk(5);
    // R11 reset state
    check(v0 == 0 && dout0 == 0, "R11", {v0, dout0}, 0);

    // R1 R4 R9: single-device sweep over every code and channel, with surplus bits
    chain_en = 1'b0;
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 16; a++) begin
        logic [17:0] w;
        w = mk(m, a, (a * 257 + m * 1365 + 7) & 12'hfff);
        open_frame();
        send18(w);
        pulse(~w[0]); pulse(w[0]); pulse(~w[1]);
        close_frame();
        if (m == 3) check(n0 == 0, "R9", n0, 0);
        else check(n0 == 1 && got0 == w, "R1/R4", got0, w);
      end
    // R6 dout held low in single-device mode
    check(dout0 == 0, "R6", dout0, 0);

    // R5 abort after every short length
    for (int k = 0; k < 18; k++) begin
      open_frame();
      for (int i = 0; i < k; i++) pulse(1'b0);
      close_frame();
      check(n0 == 0, "R5", n0, 0);
    end

    // R3 count cleared by a new frame after an aborted one
    open_frame();
    for (int i = 0; i < 7; i++) pulse(1'b1);
    close_frame();
    open_frame(); send18(mk(1, 9, 12'h5a3)); close_frame();
    check(n0 == 1 && got0 == mk(1, 9, 12'h5a3), "R3", got0, mk(1, 9, 12'h5a3));

    // R10 edges dropped while busy
    open_frame();
    begin
      logic [17:0] w = mk(2, 6, 12'h9c4);
      for (int i = 17; i >= 9; i--) pulse(w[i]);
      busy_n = 1'b0;
      pulse(1'b1); pulse(1'b0); pulse(1'b1); pulse(1'b1);
      busy_n = 1'b1;
      for (int i = 8; i >= 0; i--) pulse(w[i]);
      close_frame();
      check(n0 == 1 && got0 == w, "R10", got0, w);
    end

    // R7 chained commit keeps the last 18 bits
    chain_en = 1'b1; wait_clk(H);
    for (int a = 0; a < 16; a++) begin
      logic [17:0] w;
      w = mk(1 + (a & 1), a, (a * 4001 + 91) & 12'hfff);
      open_frame();
      for (int i = 0; i < 5; i++) pulse(i[0]);
      send18(w);
      close_frame();
      check(n0 == 1 && got0 == w, "R7", got0, w);
    end

    // R8 chained abort
    open_frame();
    for (int i = 0; i < 17; i++) pulse(1'b1);
    close_frame();
    check(n0 == 0, "R8", n0, 0);

    // R2 clock edges outside a frame leave the held bits alone
    open_frame(); send18(mk(1, 15, 0)); close_frame();
    check(n0 == 1 && got0 == mk(1, 15, 0), "R7", got0, mk(1, 15, 0));
    for (int i = 0; i < 5; i++) pulse(1'b1);
    n0 = 0; frame_n = 1'b0; wait_clk(H);
    sclk = 1'b1; wait_clk(H);
    check(dout0 == 0, "R2", dout0, 0);
    sclk = 1'b0; wait_clk(H);
    close_frame();
    check(n0 == 0, "R8", n0, 0);

    // R6 R9: two-device chain, far word first
    open_frame(); send18(mk(0, 5, 12'habc)); send18(mk(3, 2, 12'h123)); close_frame();
    check(n0 == 0, "R9", n0, 0);
    check(n1 == 1 && got1 == mk(0, 5, 12'habc), "R6", got1, mk(0, 5, 12'habc));
    open_frame(); send18(mk(3, 7, 12'hfff)); send18(mk(2, 12, 12'h0f1)); close_frame();
    check(n0 == 1 && got0 == mk(2, 12, 12'h0f1), "R7", got0, mk(2, 12, 12'h0f1));
    check(n1 == 0, "R9", n1, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule